// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Datapath

This block is the datapath of a 32-bit processor that completes one instruction in each clock cycle. It holds the program counter, a word-addressed instruction store, a 32-entry general register file, the arithmetic unit, a word-addressed data store, and the multiplexers that steer operands, results and the next program counter. Every steering choice is a plain input pin. An external decoder looks at the exported instruction word and the zero flag, then drives those pins in the same cycle.

The instruction store is filled through a simple write port, normally while reset is held. The bench acts as the controller. Register numbers come from fixed fields of the instruction word. The immediate is the low half-word, sign-extended. A taken branch adds that immediate, unshifted, to the incremented program counter.

Top module: `scdp_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0. The exported instruction is always the instruction-store word indexed by program counter bits above bit 1.
- R2: When the branch select is 0, each clock edge outside reset advances the program counter by 4.
- R3: When the branch select is 1, the next program counter is the current one plus 4 plus the sign-extended immediate (bits 15:0, with bit 15 replicated into bits 31:16).
- R4: The first register operand is addressed by instruction bits 25:21 and the second by bits 20:16. Register 0 reads as zero, and writes to it are ignored.
- R5: The destination register is bits 20:16 when the destination select is 0, and bits 15:11 when it is 1. A register changes on a clock edge only when the register-write enable is 1.
- R6: The second arithmetic operand is the second register value when the operand select is 0, and the sign-extended immediate when it is 1.
- R7: Operation codes 0000 AND, 0001 OR, 0010 add, 0110 subtract, 0111 signed set-less-than (result 1 or 0) and 1100 NOR produce their results. Every other code produces 0.
- R8: The zero flag is 1 exactly when the arithmetic result is 0.
- R9: The data store is indexed by result bits above bit 1. With the write enable at 1, it stores the second register value on the clock edge. Its read data is the addressed word when the read enable is 1, and 0 otherwise.
- R10: The value written back is the arithmetic result when the result select is 0, and the data-store read data when it is 1.
- R11: A word presented on the instruction-load port with its enable at 1 is stored at the given word index on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_we | input | 1 | Instruction-load enable |
| imem_addr | input | IMEM_AW | Instruction-load word index |
| imem_wdata | input | 32 | Instruction word to load |
| reg_dst | input | 1 | Destination select: 0 bits 20:16, 1 bits 15:11 |
| reg_write | input | 1 | Register-write enable |
| alu_src | input | 1 | Operand select: 0 register, 1 immediate |
| alu_op | input | 4 | Arithmetic operation code |
| mem_read | input | 1 | Data-store read enable |
| mem_write | input | 1 | Data-store write enable |
| mem_to_reg | input | 1 | Result select: 0 arithmetic, 1 data store |
| pc_src | input | 1 | Branch select: 0 sequential, 1 relative target |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Current instruction word |
| alu_res_o | output | 32 | Arithmetic result |
| zero_o | output | 1 | Result-is-zero flag |
| mem_rdata_o | output | 32 | Data-store read data |

## Verification
Every defined operation code and every undefined one is swept over operand pairs. The pairs include the most negative half-word immediate, minus one, equal operands and register 0 as a source. A design that compared unsigned in set-less-than, zero-extended the immediate or left stray results on undefined codes would then show a wrong result or zero flag.

Stores use an address with nonzero low bits, and one store is issued with its enable low. Loads are issued with the read enable low. A byte-indexed store, or a read-data path that leaks stale words, would then return the wrong value on a later load.

The branch tests cover a not-taken branch with a nonzero immediate, a forward skip over instructions that would write registers, and a backward branch. A design that shifted the offset or ignored its sign would land on the wrong word. Writes to register 0 and writes with the enable low are read back afterwards, so a design that let either take effect would return the wrong register value.

// File: rtl/scdp_pkg.sv
package scdp_pkg;

    localparam int XLEN   = 32;
    localparam int RNUM_W = 5;

    // Instruction field positions
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;
    localparam int IMM_W   = 16;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_code_e;

    typedef struct packed {
        logic             reg_dst;
        logic             reg_write;
        logic             alu_src;
        logic [3:0]       alu_op;
        logic             mem_read;
        logic             mem_write;
        logic             mem_to_reg;
        logic             pc_src;
    } ctl_t;

endpackage

// File: rtl/scdp_fetch.sv
module scdp_fetch
    import scdp_pkg::*;
#(
    parameter int  IMEM_WORDS = 256,
    localparam int IMEM_AW    = $clog2(IMEM_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_en,
    input  logic [IMEM_AW-1:0] load_idx,
    input  logic [XLEN-1:0]    load_word,
    input  logic               take_br,
    input  logic [XLEN-1:0]    br_ofs,
    output logic [XLEN-1:0]    pc,
    output logic [XLEN-1:0]    instr
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } fetch_st_t;

    typedef struct packed {
        logic               en;
        logic [IMEM_AW-1:0] idx;
        logic [XLEN-1:0]    word;
    } iload_t;

    fetch_st_t       st_d, st_q;
    iload_t          ld_d;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] imem_q [IMEM_WORDS];

    always_comb begin
        st_d   = st_q;
        seq_pc = st_q.pc + XLEN'(4);
        st_d.pc = take_br ? (seq_pc + br_ofs) : seq_pc;
        if (rst) begin
            st_d.pc = '0;
        end
        ld_d.en   = load_en;
        ld_d.idx  = load_idx;
        ld_d.word = load_word;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (ld_d.en) begin
            imem_q[ld_d.idx] <= ld_d.word;
        end
    end

    assign pc    = st_q.pc;
    assign instr = imem_q[st_q.pc[IMEM_AW+1:2]];

endmodule

// File: rtl/scdp_regfile.sv
module scdp_regfile
    import scdp_pkg::*;
#(
    parameter int  NREG = 32,
    localparam int RAW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2
);

    typedef struct packed {
        logic            en;
        logic [RAW-1:0]  idx;
        logic [XLEN-1:0] data;
    } rwr_t;

    rwr_t                       wr_d;
    logic [NREG-1:0][XLEN-1:0]  bank;

    always_comb begin
        wr_d.en   = we && (wa != '0);
        wr_d.idx  = wa;
        wr_d.data = wd;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        if (g == 0) begin : g_zero
            assign bank[g] = '0;
        end else begin : g_reg
            logic [XLEN-1:0] word_q;
            always_ff @(posedge clk) begin
                if (wr_d.en && (wr_d.idx == RAW'(g))) begin
                    word_q <= wr_d.data;
                end
            end
            assign bank[g] = word_q;
        end
    end

    assign rd1 = bank[ra1];
    assign rd2 = bank[ra2];

endmodule

// File: rtl/scdp_alu.sv
module scdp_alu
    import scdp_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [3:0]      code,
    output logic [XLEN-1:0] res,
    output logic            zero
);

    always_comb begin
        case (code)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_SLT:  res = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            OP_NOR:  res = ~(a | b);
            default: res = '0;
        endcase
        zero = (res == '0);
    end

endmodule

// File: rtl/scdp_dmem.sv
module scdp_dmem
    import scdp_pkg::*;
#(
    parameter int  DMEM_WORDS = 64,
    localparam int DAW        = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [DAW-1:0]  idx,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);

    typedef struct packed {
        logic            en;
        logic [DAW-1:0]  idx;
        logic [XLEN-1:0] data;
    } dwr_t;

    dwr_t            wr_d;
    logic [XLEN-1:0] mem_q [DMEM_WORDS];

    always_comb begin
        wr_d.en   = wr_en;
        wr_d.idx  = idx;
        wr_d.data = wdata;
        rdata     = rd_en ? mem_q[idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (wr_d.en) begin
            mem_q[wr_d.idx] <= wr_d.data;
        end
    end

endmodule

// File: rtl/scdp_core.sv
module scdp_core
    import scdp_pkg::*;
#(
    parameter int  IMEM_WORDS = 256,
    parameter int  DMEM_WORDS = 64,
    parameter int  NREG       = 32,
    localparam int IMEM_AW    = $clog2(IMEM_WORDS),
    localparam int DMEM_AW    = $clog2(DMEM_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               imem_we,
    input  logic [IMEM_AW-1:0] imem_addr,
    input  logic [XLEN-1:0]    imem_wdata,
    input  logic               reg_dst,
    input  logic               reg_write,
    input  logic               alu_src,
    input  logic [3:0]         alu_op,
    input  logic               mem_read,
    input  logic               mem_write,
    input  logic               mem_to_reg,
    input  logic               pc_src,
    output logic [XLEN-1:0]    pc_o,
    output logic [XLEN-1:0]    instr_o,
    output logic [XLEN-1:0]    alu_res_o,
    output logic               zero_o,
    output logic [XLEN-1:0]    mem_rdata_o
);

    typedef struct packed {
        logic [RNUM_W-1:0] wr_idx;
        logic [XLEN-1:0]   opb;
        logic [XLEN-1:0]   wb;
    } dp_sel_t;

    logic [XLEN-1:0]    instr_w;
    logic [RNUM_W-1:0]  rs_w, rt_w, rd_w;
    logic [XLEN-1:0]    imm_w;
    logic [XLEN-1:0]    rd1_w, rd2_w;
    logic [XLEN-1:0]    res_w;
    logic               zero_w;
    logic [XLEN-1:0]    mrd_w;
    logic [DMEM_AW-1:0] dm_idx_w;
    logic [RNUM_W-1:0]  wr_idx_w;
    logic [XLEN-1:0]    wb_w;
    dp_sel_t            sel;

    // Field extraction and immediate widening
    always_comb begin
        rs_w  = instr_w[RS_LSB +: RNUM_W];
        rt_w  = instr_w[RT_LSB +: RNUM_W];
        rd_w  = instr_w[RD_LSB +: RNUM_W];
        imm_w = {{(XLEN-IMM_W){instr_w[IMM_W-1]}}, instr_w[IMM_W-1:0]};
    end

    // Steering selections
    always_comb begin
        sel.wr_idx = reg_dst    ? rd_w  : rt_w;
        sel.opb    = alu_src    ? imm_w : rd2_w;
        sel.wb     = mem_to_reg ? mrd_w : res_w;
    end

    assign wr_idx_w = sel.wr_idx;
    assign wb_w     = sel.wb;
    assign dm_idx_w = res_w[DMEM_AW+1:2];

    scdp_fetch #(.IMEM_WORDS(IMEM_WORDS)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .load_en   (imem_we),
        .load_idx  (imem_addr),
        .load_word (imem_wdata),
        .take_br   (pc_src),
        .br_ofs    (imm_w),
        .pc        (pc_o),
        .instr     (instr_w)
    );

    scdp_regfile #(.NREG(NREG)) u_rf (
        .clk (clk),
        .ra1 (rs_w),
        .ra2 (rt_w),
        .we  (reg_write),
        .wa  (wr_idx_w),
        .wd  (wb_w),
        .rd1 (rd1_w),
        .rd2 (rd2_w)
    );

    scdp_alu u_alu (
        .a    (rd1_w),
        .b    (sel.opb),
        .code (alu_op),
        .res  (res_w),
        .zero (zero_w)
    );

    scdp_dmem #(.DMEM_WORDS(DMEM_WORDS)) u_dm (
        .clk   (clk),
        .rd_en (mem_read),
        .wr_en (mem_write),
        .idx   (dm_idx_w),
        .wdata (rd2_w),
        .rdata (mrd_w)
    );

    assign instr_o     = instr_w;
    assign alu_res_o   = res_w;
    assign zero_o      = zero_w;
    assign mem_rdata_o = mrd_w;

endmodule

// File: rtl/scdp_core_chk.sv
module scdp_core_chk
    import scdp_pkg::*;
#(
    parameter int DAW = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc,
    input logic              pc_src,
    input logic [XLEN-1:0]   imm,
    input logic [RNUM_W-1:0] ra1,
    input logic [XLEN-1:0]   rd1,
    input logic              we,
    input logic [RNUM_W-1:0] wa,
    input logic [XLEN-1:0]   wd,
    input logic              m_rd,
    input logic              m_wr,
    input logic [DAW-1:0]    m_idx,
    input logic [XLEN-1:0]   m_wdata,
    input logic [XLEN-1:0]   m_rdata
);

    // R1
    reset_pc_chk: assert property (@(posedge clk)
        rst |=> (pc == '0));

    // R2 R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (pc == ($past(pc) + XLEN'(4) + ($past(pc_src) ? $past(imm) : '0))));

    // R4
    r0_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ra1 == '0) |-> (rd1 == '0));

    // R5
    rf_wr_rd_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && ($past(wa) != '0) && (ra1 == $past(wa))) |-> (rd1 == $past(wd)));

    // R9
    dm_wr_rd_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(m_wr) && m_rd && (m_idx == $past(m_idx))) |-> (m_rdata == $past(m_wdata)));

endmodule

bind scdp_core scdp_core_chk #(.DAW(DMEM_AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (pc_o),
    .pc_src  (pc_src),
    .imm     (imm_w),
    .ra1     (rs_w),
    .rd1     (rd1_w),
    .we      (reg_write),
    .wa      (wr_idx_w),
    .wd      (wb_w),
    .m_rd    (mem_read),
    .m_wr    (mem_write),
    .m_idx   (dm_idx_w),
    .m_wdata (rd2_w),
    .m_rdata (mem_rdata_o)
);

// File: tb/scdp_core_bench.sv
module scdp_core_bench;
    import scdp_pkg::*;

    localparam int IW  = 256;
    localparam int IAW = 8;
    localparam int DW  = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            imem_we = 1'b0;
    logic [IAW-1:0]  imem_addr = '0;
    logic [31:0]     imem_wdata = '0;
    logic            reg_dst = 1'b0, reg_write = 1'b0, alu_src = 1'b0;
    logic [3:0]      alu_op = 4'd0;
    logic            mem_read = 1'b0, mem_write = 1'b0, mem_to_reg = 1'b0, pc_src = 1'b0;
    logic [31:0]     pc_o, instr_o, alu_res_o, mem_rdata_o;
    logic            zero_o;

    int n_chk = 0;
    int n_fail = 0;
    int nw = 0;

    logic [31:0] p_ins [IW];
    ctl_t        p_ctl [IW];
    string       p_tag [IW];
    logic [31:0] mregs [32];
    logic [31:0] mdm [DW];
    logic [31:0] mpc;

    always #4 clk = ~clk;

    scdp_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_scdp_core (
        .clk(clk), .rst(rst), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .reg_dst(reg_dst), .reg_write(reg_write),
        .alu_src(alu_src), .alu_op(alu_op), .mem_read(mem_read),
        .mem_write(mem_write), .mem_to_reg(mem_to_reg), .pc_src(pc_src),
        .pc_o(pc_o), .instr_o(instr_o), .alu_res_o(alu_res_o),
        .zero_o(zero_o), .mem_rdata_o(mem_rdata_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    function automatic logic [31:0] r_ins(input int rs, input int rt, input int rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 11'd0};
    endfunction

    function automatic logic [31:0] i_ins(input int rs, input int rt, input logic [15:0] imm);
        return {6'd8, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic ctl_t mk(input logic dst, input logic wr, input logic src, input logic [3:0] op,
                                input logic mr, input logic mw, input logic m2r, input logic br);
        ctl_t c;
        c.reg_dst = dst; c.reg_write = wr; c.alu_src = src; c.alu_op = op;
        c.mem_read = mr; c.mem_write = mw; c.mem_to_reg = m2r; c.pc_src = br;
        return c;
    endfunction

    task automatic put(input logic [31:0] ins, input ctl_t c, input string t);
        p_ins[nw] = ins; p_ctl[nw] = c; p_tag[nw] = t; nw++;
    endtask

    function automatic logic [31:0] alu_model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
        case (op)
            4'b0000: return a & b;
            4'b0001: return a | b;
            4'b0010: return a + b;
            4'b0110: return a - b;
            4'b0111: return {31'd0, ($signed(a) < $signed(b))};
            4'b1100: return ~(a | b);
            default: return 32'd0;
        endcase
    endfunction

    task automatic build();
        logic [15:0] init_v [15];
        int          prs [4];
        int          prt [4];
        int          x;
        init_v = '{16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0005, 16'h0003, 16'h0000,
                   16'h1234, 16'hFFFE, 16'h0064, 16'h0007, 16'h00FF, 16'h000C, 16'hFF9C, 16'h0002};
        prs = '{5, 2, 4, 0};
        prt = '{6, 1, 4, 2};
        // R5 R6: immediate loads into r1..r15 through bits 20:16
        for (int r = 1; r <= 15; r++)
            put(i_ins(0, r, init_v[r-1]), mk(0, 1, 1, 4'b0010, 0, 0, 0, 0), "R5 R6");
        // R4: write attempt to register 0
        put(i_ins(0, 0, 16'd55), mk(0, 1, 1, 4'b0010, 0, 0, 0, 0), "R4");
        // R7 R8 R4: every operation code over operand pairs, rd in bits 15:11
        for (int code = 0; code < 16; code++)
            for (int p = 0; p < 4; p++)
                put(r_ins(prs[p], prt[p], 16 + ((code * 4 + p) % 16)),
                    mk(1, 1, 0, 4'(code), 0, 0, 0, 0), "R4 R7");
        // R5: write with enable low, then read it back
        put(r_ins(5, 6, 17), mk(1, 0, 0, 4'b0010, 0, 0, 0, 0), "R5");
        put(r_ins(17, 0, 18), mk(1, 1, 0, 4'b0001, 0, 0, 0, 0), "R5");
        // R9: stores, one with nonzero low address bits
        for (int k = 0; k < 5; k++)
            put(i_ins(0, k + 1, 16'(4 * k + ((k == 3) ? 2 : 0))),
                mk(0, 0, 1, 4'b0010, 0, 1, 0, 0), "R9");
        put(i_ins(0, 2, 16'd16), mk(0, 0, 1, 4'b0010, 0, 0, 0, 0), "R9");
        // R9 R10: loads
        for (int k = 0; k < 5; k++)
            put(i_ins(0, 20 + k, 16'(4 * k + ((k == 2) ? 1 : 0))),
                mk(0, 1, 1, 4'b0010, 1, 0, 1, 0), "R9 R10");
        put(i_ins(0, 25, 16'd0), mk(0, 1, 1, 4'b0010, 0, 0, 1, 0), "R9 R10");
        for (int k = 0; k < 6; k++)
            put(r_ins(20 + k, 0, 26), mk(1, 1, 0, 4'b0010, 0, 0, 0, 0), "R10");
        put(i_ins(0, 27, 16'd4), mk(0, 1, 1, 4'b0010, 1, 0, 0, 0), "R10");
        put(r_ins(27, 0, 26), mk(1, 1, 0, 4'b0010, 0, 0, 0, 0), "R10");
        // R2: branch select low with nonzero offset
        put(i_ins(0, 0, 16'd8), mk(0, 0, 0, 4'b0110, 0, 0, 0, 0), "R2");
        // R3: forward, backward and forward again
        x = nw;
        put(i_ins(0, 0, 16'd8), mk(0, 0, 0, 4'b0110, 0, 0, 0, 1), "R3");
        put(i_ins(0, 28, 16'd77), mk(0, 1, 1, 4'b0010, 0, 0, 0, 0), "R3 R5");
        put(i_ins(0, 0, 16'd8), mk(0, 0, 0, 4'b0110, 0, 0, 0, 1), "R3");
        put(i_ins(0, 0, 16'hFFF4), mk(0, 0, 0, 4'b0110, 0, 0, 0, 1), "R3");
        put(i_ins(0, 1, 16'd999), mk(0, 1, 1, 4'b0010, 0, 0, 0, 0), "R3");
        if (nw != x + 5) $display("bench layout error");
        put(r_ins(28, 0, 29), mk(1, 1, 0, 4'b0001, 0, 0, 0, 0), "R3 R5");
    endtask

    task automatic step();
        int          w;
        ctl_t        c;
        logic [31:0] ins, imm, a, b, res, rdat, wb;
        logic [4:0]  wr;
        w   = int'(mpc[IAW+1:2]);
        c   = p_ctl[w];
        ins = p_ins[w];
        reg_dst = c.reg_dst; reg_write = c.reg_write; alu_src = c.alu_src; alu_op = c.alu_op;
        mem_read = c.mem_read; mem_write = c.mem_write; mem_to_reg = c.mem_to_reg; pc_src = c.pc_src;
        #1;
        chk("R1 R11", "instr", instr_o, ins);
        imm  = {{16{ins[15]}}, ins[15:0]};
        a    = mregs[ins[25:21]];
        b    = c.alu_src ? imm : mregs[ins[20:16]];
        res  = alu_model(a, b, c.alu_op);
        rdat = c.mem_read ? mdm[res[7:2]] : 32'd0;
        chk({p_tag[w], " R6 R7"}, "alu result", alu_res_o, res);
        chk("R8", "zero flag", {31'd0, zero_o}, {31'd0, (res == 32'd0)});
        chk("R9", "mem read data", mem_rdata_o, rdat);
        if (c.mem_write) mdm[res[7:2]] = mregs[ins[20:16]];
        wr = c.reg_dst ? ins[15:11] : ins[20:16];
        wb = c.mem_to_reg ? rdat : res;
        if (c.reg_write && wr != 5'd0) mregs[wr] = wb;
        mpc = mpc + 32'd4 + (c.pc_src ? imm : 32'd0);
        @(negedge clk);
        chk(c.pc_src ? "R3" : "R2", "pc", pc_o, mpc);
    endtask

    initial begin
        #(8 * 20000);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        int steps;
        int end_w;
        build();
        end_w = nw;
        for (int i = 0; i < 32; i++) mregs[i] = 32'd0;
        for (int i = 0; i < DW; i++) mdm[i] = 32'd0;
        repeat (2) @(negedge clk);
        // R11: program load while reset is held
        for (int w = 0; w < nw; w++) begin
            imem_we = 1'b1; imem_addr = IAW'(w); imem_wdata = p_ins[w];
            @(negedge clk);
        end
        imem_we = 1'b0;
        @(negedge clk);
        chk("R1", "pc in reset", pc_o, 32'd0);
        chk("R1 R11", "first instr", instr_o, p_ins[0]);
        rst = 1'b0;
        mpc = 32'd0;
        steps = 0;
        while (int'(mpc[IAW+1:2]) != end_w && steps < 1000) begin
            step();
            steps++;
        end
        chk("R3", "program end reached", 32'(steps < 1000), 32'd1);
        // R1: reset in mid-run
        rst = 1'b1; pc_src = 1'b0;
        @(negedge clk);
        chk("R1", "pc after reset", pc_o, 32'd0);
        chk("R1", "instr after reset", instr_o, p_ins[0]);
        rst = 1'b0;
        summary();
        $finish;
    end

endmodule